// File: doc/BRIEF.md
# Scaled-Index Address Adder

This combinational unit forms memory addresses for a 64-bit integer datapath. It multiplies an index operand by 2, 4 or 8 through a left shift and adds a base operand. It also has word-index forms, which first zero-extend the low 32 bits of the index. A separate placement operation deposits a zero-extended 32-bit word at a chosen bit position. The caller picks one of eight operations with a 3-bit selector, and the result appears on the output in the same cycle.

All sums wrap modulo 2^64. There is no carry or overflow output. The word-index forms and the placement operation exist only for 64-bit execution. When the narrow-mode input is high, those operations raise an illegal flag and return zero. The plain scaled adds still work in narrow mode.

Top module: `shadd_agu`

## Requirements
- R1: Selector codes 0, 1 and 2 give (index << N) + base for N = 1, 2 and 3, truncated to 64 bits.
- R2: Selector code 3 gives the zero-extended low 32 bits of index plus base. Index bits 63:32 have no effect.
- R3: Selector codes 4, 5 and 6 zero-extend index bits 31:0, shift the value left by 1, 2 and 3, then add base.
- R4: Selector code 7 writes index bits 31:0 starting at bit position shamt and sets every other bit to zero. The field is min(32, 64 - shamt) bits wide, so bits pushed past bit 63 are lost.
- R5: The shamt input has no effect for selector codes 0 to 6.
- R6: When narrow_mode_i is 1 and the selector is 3 to 7, illegal_o is 1 and result_o is zero.
- R7: When narrow_mode_i is 1 and the selector is 0 to 2, illegal_o is 0 and the result is the same as in 64-bit mode.
- R8: Sums that exceed 64 bits wrap silently, and illegal_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| index_i | input | 64 | Operand that is shifted, or zero-extended from its low word |
| base_i | input | 64 | Operand that is added unshifted |
| op_sel_i | input | 3 | Operation selector, codes 0 to 7 as listed in the requirements |
| shamt_i | input | 6 | Bit position for the word placement (code 7) |
| narrow_mode_i | input | 1 | 1 when the datapath runs in 32-bit mode |
| result_o | output | 64 | Computed address or placed word |
| illegal_o | output | 1 | Operation not allowed in narrow mode |

## Verification
The unit has no state, so a fault shows on result_o and illegal_o in the same cycle as the stimulus. A wrong shift distance shows as scaled low bits that disagree with the base. A missing zero-extension shows when index bits 63:32 are nonzero. A wrong field clip in the placement operation shows only at shamt values above 32. For that reason the stimulus sets the high index bits and covers shift positions at and beyond 32.

// File: rtl/shadd_agu.sv
module shadd_agu #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         index_i,
  input  logic [XLEN-1:0]         base_i,
  input  logic [2:0]              op_sel_i,
  input  logic [$clog2(XLEN)-1:0] shamt_i,
  input  logic                    narrow_mode_i,
  output logic [XLEN-1:0]         result_o,
  output logic                    illegal_o
);
  localparam int WORD = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  localparam logic [2:0] OP_SH1    = 3'd0;
  localparam logic [2:0] OP_SH2    = 3'd1;
  localparam logic [2:0] OP_SH3    = 3'd2;
  localparam logic [2:0] OP_ADDW   = 3'd3;
  localparam logic [2:0] OP_SH1W   = 3'd4;
  localparam logic [2:0] OP_SH2W   = 3'd5;
  localparam logic [2:0] OP_SH3W   = 3'd6;
  localparam logic [2:0] OP_PLACEW = 3'd7;

  logic [XLEN-1:0] word_z;
  logic [XLEN-1:0] scaled;
  logic [XLEN-1:0] full_val;
  logic            wide_only;

  assign word_z    = {{(XLEN-WORD){1'b0}}, index_i[WORD-1:0]};
  assign wide_only = (op_sel_i >= OP_ADDW);

  always_comb begin
    case (op_sel_i)
      OP_SH1:    scaled = index_i << 1;
      OP_SH2:    scaled = index_i << 2;
      OP_SH3:    scaled = index_i << 3;
      OP_ADDW:   scaled = word_z;
      OP_SH1W:   scaled = word_z << 1;
      OP_SH2W:   scaled = word_z << 2;
      OP_SH3W:   scaled = word_z << 3;
      default:   scaled = word_z << shamt_i;
    endcase
  end

  assign full_val  = (op_sel_i == OP_PLACEW) ? scaled : scaled + base_i;
  assign illegal_o = narrow_mode_i & wide_only;
  assign result_o  = illegal_o ? '0 : full_val;

  logic [XLEN-1:0] low_mask;
  assign low_mask = (XLEN'(1) << shamt_i) - XLEN'(1);

  always_comb begin
    if (!$isunknown({op_sel_i, narrow_mode_i, shamt_i, index_i, base_i})) begin
      AST_ILLEGAL_ZERO: assert (!illegal_o || result_o == '0)
        else $error("illegal op produced nonzero result"); // R6
      AST_ILLEGAL_SCOPE: assert (!illegal_o || (narrow_mode_i && op_sel_i >= OP_ADDW))
        else $error("illegal flag raised outside narrow word ops"); // R7
      AST_PLACE_LOW_ZERO: assert (narrow_mode_i || op_sel_i != OP_PLACEW || (result_o & low_mask) == '0)
        else $error("bits below placement not zero"); // R4
      AST_SCALED_LOW_BITS: assert (op_sel_i > OP_SH3 ||
                                   result_o[0] == base_i[0])
        else $error("scaled add disturbed base bit 0"); // R1
      AST_WORD_ADD_HIGH: assert (narrow_mode_i || op_sel_i != OP_ADDW || base_i != '0 ||
                                 result_o[XLEN-1:WORD] == '0)
        else $error("word add leaked high index bits"); // R2
    end
  end

  logic unused_shw;
  assign unused_shw = ^SHW;
endmodule

// File: tb/shadd_agu_tb.sv
module shadd_agu_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [63:0] index_i, base_i, result_o;
  logic [2:0]  op_sel_i;
  logic [5:0]  shamt_i;
  logic        narrow_mode_i, illegal_o;

  int total = 0;
  int bad   = 0;

  shadd_agu #(.XLEN(64)) dut_i (
    .index_i(index_i), .base_i(base_i), .op_sel_i(op_sel_i), .shamt_i(shamt_i),
    .narrow_mode_i(narrow_mode_i), .result_o(result_o), .illegal_o(illegal_o)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [2:0] op, input logic [5:0] sh);
    logic [63:0] w;
    w = {32'h0, a[31:0]};
    case (op)
      3'd0: return (a << 1) + b;
      3'd1: return (a << 2) + b;
      3'd2: return (a << 3) + b;
      3'd3: return w + b;
      3'd4: return (w << 1) + b;
      3'd5: return (w << 2) + b;
      3'd6: return (w << 3) + b;
      default: return w << sh;
    endcase
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [2:0] op,
                       input logic [5:0] sh, input logic nm);
    @(posedge clk);
    #1;
    index_i = a; base_i = b; op_sel_i = op; shamt_i = sh; narrow_mode_i = nm;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] exp_r, input logic exp_ill);
    total++;
    if (result_o !== exp_r || illegal_o !== exp_ill) begin
      bad++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               req, result_o, illegal_o, exp_r, exp_ill);
    end
  endtask

  localparam int NV = 10;
  localparam logic [63:0] VA [NV] = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0001,
    64'h8000_0000_8000_0000, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_FFFF_FFFF,
    64'h7FFF_FFFF_FFFF_FFFF, 64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0001_0000_0000, 64'hA5A5_5A5A_0F0F_F0F0};
  localparam logic [63:0] VB [NV] = '{64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1,
    64'h0, 64'h8000_0000_0000_0000, 64'h1234, 64'hFFFF_0000_FFFF_0000, 64'h2,
    64'h0000_0000_0000_0010, 64'h5A5A_A5A5_F0F0_0F0F};
  localparam logic [5:0] VS [NV] = '{6'd0, 6'd1, 6'd31, 6'd32, 6'd33, 6'd40,
    6'd48, 6'd63, 6'd17, 6'd5};

  initial begin
    index_i = '0; base_i = '0; op_sel_i = '0; shamt_i = '0; narrow_mode_i = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle zero inputs", 64'h0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      for (int op = 0; op < 8; op++) begin
        apply(VA[v], VB[v], 3'(op), VS[v], 1'b0);
        check(op < 3 ? "R1 table" : (op == 3 ? "R2 table" : (op < 7 ? "R3 table" : "R4 table")),
              model(VA[v], VB[v], 3'(op), VS[v]), 1'b0);
      end
    end

    apply(64'd1, 64'd2, 3'd2, 6'd0, 1'b0);             check("R1 sh3 small", 64'd10, 1'b0);
    apply(64'h8000_0000_0000_0001, 64'd0, 3'd0, 6'd0, 1'b0);
    check("R8 wrap sh1", 64'd2, 1'b0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'd3, 6'd0, 1'b0);
    check("R2 word add high ignored", 64'h1_0000_0000, 1'b0);
    apply(64'hABCD_0000_8000_0001, 64'd0, 3'd5, 6'd0, 1'b0);
    check("R3 sh2 word", 64'h2_0000_0004, 1'b0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 3'd7, 6'd40, 1'b0);
    check("R4 place clip 40", 64'hFFFF_FF00_0000_0000, 1'b0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 3'd7, 6'd63, 1'b0);
    check("R4 place 63", 64'h8000_0000_0000_0000, 1'b0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 3'd7, 6'd0, 1'b0);
    check("R4 place 0", 64'h0000_0000_FFFF_FFFF, 1'b0);
    apply(64'd3, 64'd4, 3'd0, 6'd63, 1'b0);            check("R5 shamt ignored sh1", 64'd10, 1'b0);
    apply(64'd3, 64'd4, 3'd6, 6'd21, 1'b0);            check("R5 shamt ignored sh3w", 64'd28, 1'b0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 3'd7, 6'd4, 1'b1);
    check("R6 narrow place", 64'h0, 1'b1);
    apply(64'd9, 64'd7, 3'd3, 6'd0, 1'b1);             check("R6 narrow word add", 64'h0, 1'b1);
    apply(64'd9, 64'd7, 3'd4, 6'd0, 1'b1);             check("R6 narrow sh1 word", 64'h0, 1'b1);
    apply(64'd3, 64'd4, 3'd0, 6'd0, 1'b1);             check("R7 narrow sh1", 64'd10, 1'b0);
    apply(64'd3, 64'd4, 3'd2, 6'd0, 1'b1);             check("R7 narrow sh3", 64'd28, 1'b0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd6, 6'd0, 1'b0);
    check("R8 wrap sh3 word", 64'h0000_0007_FFFF_FFF7, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule